// File: doc/BRIEF.md
# Multi-mode DMA channel sequencer

This block is a single DMA channel. A start strobe loads a configuration and arms the channel. The configuration holds the mode, the transfer type, the block size, the transfer count and the source and destination addresses. Once armed, the channel waits for a transfer request. When a request is detected, it asks an external arbiter for the bus and holds that request until the grant arrives. It then runs data cycles on a simple single-cycle memory port. When the configured amount has been moved, it reports completion and disarms itself.

The mode sets how much data one request moves:

- **Block/step:** one block per request edge.
- **Burst:** the whole count from one edge.
- **Demand:** unit after unit while the request level stays high.

The transfer type sets what one unit is:

- **Two-cycle:** a read followed by a write.
- **Fly-by:** a single flagged read. The external side takes the data itself.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is disarmed (`en_o` low). `start_i` loads the configuration and arms the channel only while it is disarmed. Requests seen while disarmed cause no bus request and no data cycle.
- R2: A detected request first raises `bus_req_o` with no data cycle. No read or write is issued until `bus_gnt_i` has been sampled high. `bus_req_o` stays high through every data cycle.
- R3: The mode field encodes 00 as block/step, 01 as burst and 10 as demand. Code 11 behaves exactly like block/step.
- R4: In block/step mode, each request moves `cfg_blk_i`+1 units (1 to 16). The channel then drops `bus_req_o` and waits for the next request. It finishes after `cfg_cnt_i` blocks.
- R5: In burst mode, one request moves (`cfg_blk_i`+1)×`cfg_cnt_i` units back to back, without dropping `bus_req_o`.
- R6: In demand mode, the request is taken as a level and the block size is treated as 1, whatever `cfg_blk_i` holds. The channel finishes after `cfg_cnt_i` units.
- R7: In a two-cycle transfer, a unit is one read cycle at the source address. It is followed in the next cycle by one write cycle at the destination address, carrying the data returned by the read.
- R8: In a fly-by transfer, a unit is a single read cycle with `mem_flyby_o` high, and no write cycle occurs.
- R9: After each unit the source address advances by one. The destination address advances by one only for two-cycle transfers.
- R10: `done_o` pulses for exactly one cycle, the cycle after the last unit. In that cycle `en_o` and `bus_req_o` are already low.
- R11: In demand mode, if the request is low when a unit completes, the bus is released and the remaining count is kept. The transfer resumes on the next assertion.
- R12: In block/step and burst modes, only a rising edge of `req_i` seen while waiting starts a transfer. A request held high across the end of a block, or an edge during a transfer, starts nothing.
- R13: A start with `cfg_cnt_i` equal to zero is ignored, and the channel stays disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load configuration and arm |
| cfg_mode_i | input | 2 | Transfer mode |
| cfg_flyby_i | input | 1 | 1 = fly-by, 0 = two-cycle |
| cfg_blk_i | input | BW (4) | Block size minus one |
| cfg_cnt_i | input | CW (16) | Transfer count |
| cfg_src_i | input | AW (16) | Source start address |
| cfg_dst_i | input | AW (16) | Destination start address |
| req_i | input | 1 | Transfer request |
| bus_req_o | output | 1 | Bus request to arbiter |
| bus_gnt_i | input | 1 | Bus grant from arbiter |
| mem_rd_o | output | 1 | Read cycle |
| mem_wr_o | output | 1 | Write cycle |
| mem_flyby_o | output | 1 | Read cycle is fly-by |
| mem_addr_o | output | AW (16) | Cycle address |
| mem_rdata_i | input | DW (16) | Read data, same cycle |
| mem_wdata_o | output | DW (16) | Write data |
| en_o | output | 1 | Channel armed |
| done_o | output | 1 | Completion pulse |

## Verification
The hardest situation to reach is a demand transfer interrupted part way through a count, where the request falls and then rises again. The stimulus holds the request for a few cycles behind a grant that arrives late, then drops it mid-unit. The bench confirms the channel stays armed with no completion, then reasserts the request until the remainder drains. A second hard case is a request edge that lands during a block, or a request held high across a block boundary. The stimulus creates both, and the bench checks that neither starts a new block.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    MODE_BLOCK  = 2'b00,
    MODE_BURST  = 2'b01,
    MODE_DEMAND = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_BREQ,
    ST_RD,
    ST_WR
  } state_e;
endpackage

// File: rtl/dma_req_detect.sv
module dma_req_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic level_i,
  output logic trig_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_i;
  end

  assign trig_o = level_i ? req_i : (req_i & ~req_q);
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int BW = 4,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW:0]   blk_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          step_i,
  output logic          blk_end_o,
  output logic          last_o
);
  logic [BW:0]   blk_size_q, blk_left_q;
  logic [CW-1:0] blocks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_size_q <= '0;
      blk_left_q <= '0;
      blocks_q   <= '0;
    end else if (load_i) begin
      blk_size_q <= blk_i;
      blk_left_q <= blk_i;
      blocks_q   <= cnt_i;
    end else if (step_i) begin
      if (blk_end_o) begin
        blk_left_q <= blk_size_q;
        blocks_q   <= blocks_q - CW'(1);
      end else begin
        blk_left_q <= blk_left_q - (BW+1)'(1);
      end
    end
  end

  assign blk_end_o = (blk_left_q == (BW+1)'(1));
  assign last_o    = blk_end_o && (blocks_q == CW'(1));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          step_i,
  input  logic          flyby_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o <= '0;
      dst_o <= '0;
    end else if (load_i) begin
      src_o <= src_i;
      dst_o <= dst_i;
    end else if (step_i) begin
      src_o <= src_o + AW'(1);
      if (!flyby_i) dst_o <= dst_o + AW'(1);
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BW = 4,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    cfg_mode_i,
  input  logic          cfg_flyby_i,
  input  logic [BW-1:0] cfg_blk_i,
  input  logic [CW-1:0] cfg_cnt_i,
  input  logic [AW-1:0] cfg_src_i,
  input  logic [AW-1:0] cfg_dst_i,
  input  logic          req_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          mem_flyby_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o,
  output logic          en_o,
  output logic          done_o
);
  state_e        state_q, state_d, after_unit;
  mode_e         mode_q;
  logic          fly_q, done_q;
  logic [DW-1:0] data_q;
  logic          load, step, trig, blk_end, last;
  logic          demand, stepwise;
  logic [BW:0]   eff_blk;
  logic [AW-1:0] src, dst;

  assign load     = (state_q == ST_OFF) && start_i && (cfg_cnt_i != '0);
  assign demand   = (mode_q == MODE_DEMAND);
  assign stepwise = (mode_q == MODE_BLOCK) || (mode_q == MODE_RSVD);
  assign step     = ((state_q == ST_RD) && fly_q) || (state_q == ST_WR);
  // demand mode forces a block of one
  assign eff_blk  = (mode_e'(cfg_mode_i) == MODE_DEMAND) ? (BW+1)'(1)
                                                         : {1'b0, cfg_blk_i} + (BW+1)'(1);

  dma_req_detect u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .level_i (demand),
    .trig_o  (trig)
  );

  dma_xfer_cnt #(.BW(BW), .CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .blk_i     (eff_blk),
    .cnt_i     (cfg_cnt_i),
    .step_i    (step),
    .blk_end_o (blk_end),
    .last_o    (last)
  );

  dma_addr_gen #(.AW(AW)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .src_i   (cfg_src_i),
    .dst_i   (cfg_dst_i),
    .step_i  (step),
    .flyby_i (fly_q),
    .src_o   (src),
    .dst_o   (dst)
  );

  always_comb begin
    if (last)                     after_unit = ST_OFF;
    else if (demand)              after_unit = req_i ? ST_RD : ST_WAIT;
    else if (stepwise && blk_end) after_unit = ST_WAIT;
    else                          after_unit = ST_RD;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:  if (load) state_d = ST_WAIT;
      ST_WAIT: if (trig) state_d = ST_BREQ;
      ST_BREQ: if (bus_gnt_i) state_d = ST_RD;
      ST_RD:   state_d = fly_q ? after_unit : ST_WR;
      ST_WR:   state_d = after_unit;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      mode_q  <= MODE_BLOCK;
      fly_q   <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= step && last;
      if (load) begin
        mode_q <= mode_e'(cfg_mode_i);
        fly_q  <= cfg_flyby_i;
      end
      if (state_q == ST_RD) data_q <= mem_rdata_i;
    end
  end

  assign bus_req_o   = (state_q == ST_BREQ) || (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_rd_o    = (state_q == ST_RD);
  assign mem_wr_o    = (state_q == ST_WR);
  assign mem_flyby_o = (state_q == ST_RD) && fly_q;
  assign mem_addr_o  = (state_q == ST_WR) ? dst : src;
  assign mem_wdata_o = data_q;
  assign en_o        = (state_q != ST_OFF);
  assign done_o      = done_q;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_req_o,
  input logic mem_rd_o,
  input logic mem_wr_o,
  input logic mem_flyby_o,
  input logic en_o,
  input logic done_o
);
  p_data_needs_bus_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> bus_req_o);

  p_no_data_on_req_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> !(mem_rd_o || mem_wr_o));

  p_wr_follows_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($past(mem_rd_o) && !$past(mem_flyby_o)));

  p_rd_wr_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o}));

  p_flyby_is_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_flyby_o |-> mem_rd_o);

  p_flyby_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_flyby_o |=> !mem_wr_o);

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_released_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!en_o && !bus_req_o));

  p_bus_only_armed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> en_o);
endmodule

bind dma_chan_seq dma_chan_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_o   (bus_req_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_flyby_o (mem_flyby_o),
  .en_o        (en_o),
  .done_o      (done_o)
);

// File: tb/tb_dma_chan_seq.sv
`timescale 1ns/1ps
module tb_dma_chan_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 0, cfg_flyby = 0, req = 0, gnt = 0;
  logic [1:0]  cfg_mode = 0;
  logic [3:0]  cfg_blk = 0;
  logic [15:0] cfg_cnt = 0, cfg_src = 0, cfg_dst = 0;
  logic        bus_req, rd, wr, fly, en, done;
  logic [15:0] addr, rdata, wdata;

  function automatic logic [15:0] rd_fn(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8]};
  endfunction
  assign rdata = rd_fn(addr);

  dma_chan_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_mode_i(cfg_mode),
    .cfg_flyby_i(cfg_flyby), .cfg_blk_i(cfg_blk), .cfg_cnt_i(cfg_cnt),
    .cfg_src_i(cfg_src), .cfg_dst_i(cfg_dst), .req_i(req), .bus_req_o(bus_req),
    .bus_gnt_i(gnt), .mem_rd_o(rd), .mem_wr_o(wr), .mem_flyby_o(fly),
    .mem_addr_o(addr), .mem_rdata_i(rdata), .mem_wdata_o(wdata), .en_o(en),
    .done_o(done)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // arbiter: grant after a latency while the request stays high
  int gnt_lat = 2, gl = 0;
  always @(negedge clk) begin
    if (!rst_n || !bus_req) begin gnt <= 0; gl <= 0; end
    else if (gl >= gnt_lat) gnt <= 1;
    else gl <= gl + 1;
  end

  // behavioural reference: phase 0 off,1 wait,2 bus,3 read,4 write
  int m_ph, m_moved, m_total, m_bs, m_mode;
  bit m_fly, m_done, m_prev_req;
  logic [15:0] m_src, m_dst, m_data;

  task automatic m_unit_end();
    m_src = m_src + 16'd1;
    if (!m_fly) m_dst = m_dst + 16'd1;
    m_moved++;
    if (m_moved == m_total) begin m_done = 1; m_ph = 0; end
    else if (m_mode == 2) m_ph = req ? 3 : 1;
    else if ((m_mode == 0 || m_mode == 3) && (m_moved % m_bs == 0)) m_ph = 1;
    else m_ph = 3;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_done = 0; m_prev_req = 0; m_src = 0; m_dst = 0; m_data = 0;
      m_moved = 0; m_total = 0; m_bs = 1; m_mode = 0; m_fly = 0;
    end else begin
      m_done = 0;
      case (m_ph)
        0: if (start && cfg_cnt != 0) begin
             m_mode = int'(cfg_mode); m_fly = cfg_flyby;
             m_bs = (m_mode == 2) ? 1 : int'(cfg_blk) + 1;
             m_total = m_bs * int'(cfg_cnt); m_moved = 0;
             m_src = cfg_src; m_dst = cfg_dst; m_ph = 1;
           end
        1: if ((m_mode == 2) ? req : (req && !m_prev_req)) m_ph = 2;
        2: if (gnt) m_ph = 3;
        3: begin
             m_data = rd_fn(m_src);
             if (m_fly) m_unit_end(); else m_ph = 4;
           end
        default: m_unit_end();
      endcase
      m_prev_req = req;
    end
  end

  int rd_n = 0, wr_n = 0, fly_n = 0, done_n = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(bus_req == (m_ph >= 2), "R2 bus_req", bus_req, m_ph >= 2);
      chk(rd == (m_ph == 3), "R7 rd", rd, m_ph == 3);
      chk(wr == (m_ph == 4), "R7 wr", wr, m_ph == 4);
      chk(fly == (m_ph == 3 && m_fly), "R8 flyby", fly, m_ph == 3 && m_fly);
      chk(en == (m_ph != 0), "R1 en", en, m_ph != 0);
      chk(done == m_done, "R10 done", done, m_done);
      if (rd || wr) chk(addr == ((m_ph == 4) ? m_dst : m_src), "R9 addr", addr,
                        (m_ph == 4) ? m_dst : m_src);
      if (wr) chk(wdata == m_data, "R7 wdata", wdata, m_data);
      rd_n += int'(rd); wr_n += int'(wr); fly_n += int'(fly); done_n += int'(done);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic arm(input logic [1:0] md, input bit fb, input logic [3:0] bk,
                     input logic [15:0] cn, input logic [15:0] s, input logic [15:0] d);
    cfg_mode = md; cfg_flyby = fb; cfg_blk = bk; cfg_cnt = cn; cfg_src = s; cfg_dst = d;
    start = 1; cyc(1); start = 0; cyc(1);
  endtask

  task automatic pulse_req();
    req = 1; cyc(1); req = 0; cyc(1);
  endtask

  task automatic wait_done(input string tag);
    int base = done_n;
    for (int i = 0; i < 2000 && done_n == base; i++) cyc(1);
    chk(done_n == base + 1, tag, done_n - base, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w0, r0, f0;
    cyc(3); rst_n = 1; cyc(2);
    chk(en == 0 && bus_req == 0 && rd == 0, "R1 reset idle", en, 0);

    pulse_req(); req = 1; cyc(3); req = 0; cyc(4);
    chk(rd_n == 0 && bus_req == 0, "R1 disarmed request ignored", rd_n, 0);

    arm(2'b00, 0, 4'd2, 16'd0, 16'd10, 16'd20); cyc(2);
    chk(en == 0, "R13 zero count ignored", en, 0);

    // block/step: 3-unit blocks, 2 blocks
    w0 = wr_n;
    arm(2'b00, 0, 4'd2, 16'd2, 16'd100, 16'd200);
    req = 1; cyc(2); req = 0;
    cyc(30);
    chk(wr_n - w0 == 3, "R4 one block per request", wr_n - w0, 3);
    chk(en == 1 && bus_req == 0, "R4 bus dropped between blocks", bus_req, 0);
    pulse_req(); wait_done("R10 block done");
    chk(wr_n - w0 == 6, "R7 two-cycle writes", wr_n - w0, 6);
    chk(en == 0, "R10 disarmed after done", en, 0);

    // reserved code acts as block/step; held request and mid-block edge do nothing
    w0 = wr_n; gnt_lat = 0;
    arm(2'b11, 0, 4'd1, 16'd3, 16'd500, 16'd600);
    pulse_req(); cyc(20);
    chk(wr_n - w0 == 2, "R3 code 11 moves one block", wr_n - w0, 2);
    req = 1; cyc(2); req = 0; cyc(1); req = 1; cyc(30);
    chk(wr_n - w0 == 4, "R12 held or mid-transfer request starts nothing", wr_n - w0, 4);
    req = 0; cyc(2); pulse_req(); wait_done("R3 code 11 completes");
    chk(wr_n - w0 == 6, "R3 total units", wr_n - w0, 6);

    // burst: 2-unit blocks x 3, one edge, extra edges ignored
    w0 = wr_n; gnt_lat = 3;
    arm(2'b01, 0, 4'd1, 16'd3, 16'h1234, 16'h4000);
    pulse_req(); cyc(3); pulse_req();
    wait_done("R5 burst completes from one request");
    chk(wr_n - w0 == 6, "R5 burst units", wr_n - w0, 6);
    cyc(10);
    chk(bus_req == 0 && en == 0, "R12 edge during burst not stored", bus_req, 0);

    // fly-by burst
    w0 = wr_n; r0 = rd_n; f0 = fly_n;
    arm(2'b01, 1, 4'd0, 16'd4, 16'h00FE, 16'h7000);
    pulse_req(); wait_done("R8 fly-by burst done");
    chk(rd_n - r0 == 4 && fly_n - f0 == 4, "R8 fly-by reads", fly_n - f0, 4);
    chk(wr_n - w0 == 0, "R8 no write on fly-by", wr_n - w0, 0);

    // demand with interruption and resume; block field ignored
    w0 = wr_n; gnt_lat = 2;
    arm(2'b10, 0, 4'd7, 16'd5, 16'd300, 16'd400);
    req = 1; cyc(7); req = 0; cyc(20);
    chk(en == 1 && bus_req == 0, "R11 bus released, channel kept", en, 1);
    chk(wr_n - w0 > 0 && wr_n - w0 < 5, "R11 partial count kept", wr_n - w0, 2);
    req = 1; wait_done("R6 demand completes after resume"); req = 0;
    chk(wr_n - w0 == 5, "R6 block size ignored in demand", wr_n - w0, 5);
    cyc(5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule